// File: doc/BRIEF.md
# Watchdog Safe-Frequency Controller

This block supervises a clocking subsystem. A countdown timer measures a programmable interval, counted in ticks of a fixed long period. If software does not service it with a kick before the interval runs out, the block does three things. It sets a sticky alarm flag. It replaces the active frequency-select code with a fallback code. It drives an active-low system reset pulse of fixed length.

The fallback code has two possible sources, chosen by a select input. One is a 5-bit code captured from strap pins while the block is held in reset. The other is a 5-bit code held in a configuration register. The watchdog starts out enabled or disabled according to a strap pin captured in reset. Once software writes the register enable bit, that bit takes over.

A separate option also pulses the reset output whenever the programmed frequency code changes. The length of a tick is a parameter, so simulations can use a short one. The configuration values arrive as plain input signals.

Top module: `wdsf_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `alarm` is 0, `sys_rst_n` is 1 and `fs_active` equals `sw_fs_code`.
- R2: With the watchdog enabled and no kick, `alarm` rises exactly N*TICK_CYCLES clock edges after the edge that reloaded the counter. N is `cfg_count`, and the counter reloads on a kick, while disabled, and while the alarm is set.
- R3: A `cfg_count` of 0 behaves as 1: the alarm rises TICK_CYCLES edges after the reload.
- R4: Each cycle with `kick`=1 reloads the counter and restarts the tick phase. Kicks spaced closer than the timeout keep `alarm` at 0.
- R5: The effective enable is the `strap_wden` level captured during reset until the first `cfg_en_wr` pulse. From then on it is the `cfg_en_val` written. While disabled, `alarm` never rises.
- R6: Once set, `alarm` stays 1 until a cycle with `alarm_clr`=1. It then returns to 0 and the countdown restarts from `cfg_count`.
- R7: `fs_active` equals `sw_fs_code` while `alarm` is 0. While `alarm` is 1 it equals the fallback code: `cfg_safe_src`=0 selects the captured strap code and `cfg_safe_src`=1 selects `cfg_safe_code`.
- R8: The edge that sets `alarm` also drives `sys_rst_n` low. It stays low for exactly RST_PULSE_CYCLES cycles, and a new trigger restarts the full length.
- R9: With `cfg_chg_rst_en`=1 and `alarm`=0, a change of `sw_fs_code` from its value at the previous edge starts the same reset pulse. With `cfg_chg_rst_en`=0 no pulse results.
- R10: `strap_fs` and `strap_wden` are sampled only while `rst` is high. Later changes on them have no effect on the fallback code or the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps captured while high |
| strap_fs | input | 5 | Strap frequency code pins |
| strap_wden | input | 1 | Strap watchdog enable pin |
| cfg_count | input | 8 | Timeout in ticks |
| cfg_en_wr | input | 1 | Write strobe for the register enable |
| cfg_en_val | input | 1 | Register enable value written |
| cfg_safe_code | input | 5 | Programmed fallback code |
| cfg_safe_src | input | 1 | Fallback source: 0 strap, 1 register |
| cfg_chg_rst_en | input | 1 | Reset on frequency-code change |
| sw_fs_code | input | 5 | Normal frequency-select code |
| kick | input | 1 | Service pulse, reloads the countdown |
| alarm_clr | input | 1 | Clears the alarm flag |
| alarm | output | 1 | Sticky alarm status |
| fs_active | output | 5 | Active frequency-select code |
| sys_rst_n | output | 1 | Active-low system reset pulse |

## Verification
The hardest state to reach is the exact edge of a timeout. Counter value, tick phase, a pending kick, a clear and an enable write can all change in that same cycle. The directed part reaches it by reloading with a kick and counting edges until the alarm. The random part keeps counts small and the tick short, so timeouts collide with kicks, clears, enable writes, code changes and mid-run resets. Strap pins are changed after reset to show that they are ignored.

// File: rtl/wdsf_pkg.sv
package wdsf_pkg;

    localparam int FS_W = 5;

    typedef logic [FS_W-1:0] fs_code_t;

    typedef enum logic {
        SAFE_FROM_STRAP = 1'b0,
        SAFE_FROM_REG   = 1'b1
    } safe_src_e;

    typedef struct packed {
        fs_code_t fs;
        logic     wden;
    } strap_t;

    function automatic fs_code_t pick_safe(safe_src_e src, fs_code_t strap_code, fs_code_t reg_code);
        return (src == SAFE_FROM_REG) ? reg_code : strap_code;
    endfunction

endpackage

// File: rtl/wdsf_prescaler.sv
module wdsf_prescaler #(
    parameter int TICK_CYCLES = 29_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    generate
        if (TICK_CYCLES <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_count
            localparam int PW = $clog2(TICK_CYCLES);
            localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);
            logic [PW-1:0] phase_q;

            assign tick = run && (phase_q == LAST);

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    phase_q <= '0;
                end else if (phase_q == LAST) begin
                    phase_q <= '0;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end

            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick); // R2
        end
    endgenerate
endmodule

// File: rtl/wdsf_countdown.sv
module wdsf_countdown #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             kick_i,
    input  logic             alarm_clr_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             run_o,
    output logic             expire_o,
    output logic             alarm_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             alarm_q;

    assign run_o    = en_i && !alarm_q && !kick_i;
    assign expire_o = tick_i && (cnt_q <= CNT_W'(1));
    assign alarm_o  = alarm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= load_val_i;
        end else if (!run_o) begin
            cnt_q <= load_val_i;
        end else if (tick_i && (cnt_q > CNT_W'(1))) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q <= 1'b0;
        end else if (alarm_q) begin
            if (alarm_clr_i) alarm_q <= 1'b0;
        end else if (expire_o) begin
            alarm_q <= 1'b1;
        end
    end

    AST_ALARM_FROM_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_q) |-> $past(tick_i)); // R2
    AST_ALARM_HELD: assert property (@(posedge clk) disable iff (rst)
        (alarm_q && !alarm_clr_i) |=> alarm_q); // R6
    AST_IDLE_NO_ALARM: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !alarm_q) |=> !alarm_q); // R5
endmodule

// File: rtl/wdsf_pulse.sv
module wdsf_pulse #(
    parameter int RST_PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic active_o
);
    localparam int PW = $clog2(RST_PULSE_CYCLES + 1);
    localparam logic [PW-1:0] FULL = PW'(RST_PULSE_CYCLES);

    logic [PW-1:0] cnt_q;

    assign active_o = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (trig_i) begin
            cnt_q <= FULL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_PULSE_DECAY: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0 && !trig_i) |=> (cnt_q == PW'($past(cnt_q) - 1'b1))); // R8
endmodule

// File: rtl/wdsf_top.sv
module wdsf_top
    import wdsf_pkg::*;
#(
    parameter int TICK_CYCLES      = 29_000_000,
    parameter int CNT_W            = 8,
    parameter int RST_PULSE_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [FS_W-1:0]  strap_fs,
    input  logic             strap_wden,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             cfg_en_wr,
    input  logic             cfg_en_val,
    input  logic [FS_W-1:0]  cfg_safe_code,
    input  logic             cfg_safe_src,
    input  logic             cfg_chg_rst_en,
    input  logic [FS_W-1:0]  sw_fs_code,
    input  logic             kick,
    input  logic             alarm_clr,
    output logic             alarm,
    output logic [FS_W-1:0]  fs_active,
    output logic             sys_rst_n
);
    strap_t   strap_q;
    logic     ovr_q;
    logic     en_reg_q;
    fs_code_t prev_fs_q;
    logic     en_eff;
    logic     run;
    logic     tick;
    logic     expire;
    logic     code_chg;
    logic     pulse_active;
    fs_code_t safe_code;

    // strap capture and enable ownership
    always_ff @(posedge clk) begin
        if (rst) begin
            strap_q  <= '{fs: strap_fs, wden: strap_wden};
            ovr_q    <= 1'b0;
            en_reg_q <= 1'b1;
        end else if (cfg_en_wr) begin
            ovr_q    <= 1'b1;
            en_reg_q <= cfg_en_val;
        end
    end

    assign en_eff = ovr_q ? en_reg_q : strap_q.wden;

    always_ff @(posedge clk) begin
        prev_fs_q <= sw_fs_code;
    end

    assign code_chg = cfg_chg_rst_en && !alarm && (sw_fs_code != prev_fs_q);

    wdsf_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    wdsf_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .en_i        (en_eff),
        .kick_i      (kick),
        .alarm_clr_i (alarm_clr),
        .load_val_i  (cfg_count),
        .tick_i      (tick),
        .run_o       (run),
        .expire_o    (expire),
        .alarm_o     (alarm)
    );

    wdsf_pulse #(.RST_PULSE_CYCLES(RST_PULSE_CYCLES)) u_pulse (
        .clk      (clk),
        .rst      (rst),
        .trig_i   (expire || code_chg),
        .active_o (pulse_active)
    );

    assign sys_rst_n = !pulse_active;
    assign safe_code = pick_safe(safe_src_e'(cfg_safe_src), strap_q.fs, cfg_safe_code);
    assign fs_active = alarm ? safe_code : sw_fs_code;

    AST_RESET_ON_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm) |-> !sys_rst_n); // R8
    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(strap_q)); // R10
    AST_ALARM_ZERO_AFTER_RESET: assert property (@(posedge clk)
        rst |=> !alarm); // R1
endmodule

// File: tb/wdsf_top_bench.sv
module wdsf_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T = 5;
    localparam int P = 3;

    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] strap_fs;
    logic       strap_wden;
    logic [7:0] cfg_count;
    logic       cfg_en_wr, cfg_en_val;
    logic [4:0] cfg_safe_code;
    logic       cfg_safe_src, cfg_chg_rst_en;
    logic [4:0] sw_fs_code;
    logic       kick, alarm_clr;
    logic       alarm;
    logic [4:0] fs_active;
    logic       sys_rst_n;

    int nvec = 0;
    int nfail = 0;
    int ncyc = 0;

    // reference state
    logic [4:0] m_strap_fs;
    logic       m_strap_en, m_ovr, m_en_reg, m_alarm;
    int         m_pre, m_cnt, m_pulse;
    logic [4:0] m_prev_fs;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdsf_top #(.TICK_CYCLES(T), .CNT_W(8), .RST_PULSE_CYCLES(P)) u_wdsf_top (
        .clk(clk), .rst(rst), .strap_fs(strap_fs), .strap_wden(strap_wden),
        .cfg_count(cfg_count), .cfg_en_wr(cfg_en_wr), .cfg_en_val(cfg_en_val),
        .cfg_safe_code(cfg_safe_code), .cfg_safe_src(cfg_safe_src),
        .cfg_chg_rst_en(cfg_chg_rst_en), .sw_fs_code(sw_fs_code),
        .kick(kick), .alarm_clr(alarm_clr), .alarm(alarm),
        .fs_active(fs_active), .sys_rst_n(sys_rst_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [4:0] exp_fs();
        if (!m_alarm) return sw_fs_code;
        return cfg_safe_src ? cfg_safe_code : m_strap_fs;
    endfunction

    task automatic model_step();
        logic en, run, tick, timeout, chg;
        if (rst) begin
            m_strap_fs = strap_fs; m_strap_en = strap_wden;
            m_ovr = 1'b0; m_en_reg = 1'b1; m_alarm = 1'b0;
            m_pre = 0; m_cnt = cfg_count; m_pulse = 0;
        end else begin
            en      = m_ovr ? m_en_reg : m_strap_en;
            run     = en && !m_alarm && !kick;
            tick    = run && (m_pre == T-1);
            timeout = tick && (m_cnt <= 1);
            chg     = cfg_chg_rst_en && !m_alarm && (sw_fs_code != m_prev_fs);
            if (!run) begin m_pre = 0; m_cnt = cfg_count; end
            else if (tick) begin m_pre = 0; if (m_cnt > 1) m_cnt--; end
            else m_pre++;
            if (m_alarm) begin if (alarm_clr) m_alarm = 1'b0; end
            else if (timeout) m_alarm = 1'b1;
            if (timeout || chg) m_pulse = P;
            else if (m_pulse > 0) m_pulse--;
            if (cfg_en_wr) begin m_ovr = 1'b1; m_en_reg = cfg_en_val; end
        end
        m_prev_fs = sw_fs_code;
    endtask

    // one clock: model updates at the edge, outputs compared at the falling edge
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R2 alarm", alarm, m_alarm);
        chk("R7 fs_active", fs_active, exp_fs());
        chk("R8 sys_rst_n", sys_rst_n, (m_pulse == 0));
    endtask

    task automatic idle_inputs();
        cfg_en_wr = 0; kick = 0; alarm_clr = 0;
    endtask

    task automatic do_reset(input logic [4:0] sfs, input logic swd);
        strap_fs = sfs; strap_wden = swd; rst = 1;
        repeat (3) cyc();
        rst = 0;
    endtask

    task automatic cycles_to_alarm(output int n);
        n = 0;
        while (!alarm && n < 500) begin cyc(); n++; end
    endtask

    // hang guard
    always @(posedge clk) begin
        ncyc++;
        if (ncyc > 100000) begin
            nfail++;
            $display("FAIL watchdog expired, all requirements unfinished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        int n, low, dummy;
        dummy = $urandom(32'h5eed);
        idle_inputs();
        cfg_count = 8'd3; cfg_en_val = 1; cfg_safe_code = 5'h1C; cfg_safe_src = 0;
        cfg_chg_rst_en = 0; sw_fs_code = 5'h02;
        @(negedge clk);
        do_reset(5'h13, 1'b1);
        cyc();
        // R1 state right after reset
        chk("R1 alarm", alarm, 0);
        chk("R1 sys_rst_n", sys_rst_n, 1);
        chk("R1 fs_active", fs_active, 5'h02);

        // R2 timing from a kick
        kick = 1; cyc(); kick = 0;
        cycles_to_alarm(n);
        chk("R2 edges to alarm count=3", n, 3*T);
        chk("R7 strap fallback", fs_active, 5'h13);
        low = 0;
        while (!sys_rst_n && low < 50) begin cyc(); low++; end
        chk("R8 reset low length", low, P);

        // R10 straps ignored after reset
        strap_fs = 5'h00; strap_wden = 0;
        cyc();
        chk("R10 strap code kept", fs_active, 5'h13);
        cfg_safe_src = 1; cyc();
        chk("R7 register fallback", fs_active, 5'h1C);

        // R6 sticky alarm
        repeat (30) cyc();
        chk("R6 alarm held", alarm, 1);
        alarm_clr = 1; cyc(); alarm_clr = 0;
        chk("R6 alarm cleared", alarm, 0);
        chk("R7 normal code", fs_active, 5'h02);

        // R3 count of zero
        cfg_count = 8'd0; kick = 1; cyc(); kick = 0;
        cycles_to_alarm(n);
        chk("R3 edges to alarm count=0", n, T);
        alarm_clr = 1; cyc(); alarm_clr = 0;

        // R4 regular kicks
        cfg_count = 8'd2;
        for (int i = 0; i < 64; i++) begin kick = (i % 8 == 0); cyc(); end
        kick = 0;
        chk("R4 no alarm with kicks", alarm, 0);

        // R5 register disable then enable
        cfg_en_wr = 1; cfg_en_val = 0; cyc(); cfg_en_wr = 0;
        repeat (100) cyc();
        chk("R5 disabled no alarm", alarm, 0);

        // R9 reset on code change, only when enabled
        cfg_chg_rst_en = 1; sw_fs_code = 5'h07; cyc();
        chk("R9 change pulses reset", sys_rst_n, 0);
        repeat (P) cyc();
        chk("R9 pulse ended", sys_rst_n, 1);
        cfg_chg_rst_en = 0; sw_fs_code = 5'h09; cyc();
        chk("R9 change ignored when off", sys_rst_n, 1);

        cfg_en_wr = 1; cfg_en_val = 1; cyc(); cfg_en_wr = 0;
        cycles_to_alarm(n);
        chk("R5 enabled by register write", n, 2*T);
        alarm_clr = 1; cyc(); alarm_clr = 0;

        // R5 strap disable
        do_reset(5'h0A, 1'b0);
        repeat (60) cyc();
        chk("R5 strap disabled no alarm", alarm, 0);

        // constrained random phase
        do_reset(5'h15, 1'b1);
        for (int i = 0; i < 4000; i++) begin
            kick      = ($urandom_range(15) == 0);
            alarm_clr = ($urandom_range(9) == 0);
            cfg_en_wr = ($urandom_range(39) == 0);
            cfg_en_val = ($urandom_range(3) != 0);
            if ($urandom_range(49) == 0) cfg_chg_rst_en = ~cfg_chg_rst_en;
            if ($urandom_range(11) == 0) sw_fs_code = 5'($urandom_range(31));
            if ($urandom_range(29) == 0) cfg_safe_src = ~cfg_safe_src;
            if ($urandom_range(29) == 0) cfg_count = 8'($urandom_range(5));
            if ($urandom_range(29) == 0) cfg_safe_code = 5'($urandom_range(31));
            strap_fs   = 5'($urandom_range(31));
            strap_wden = 1'($urandom_range(1));
            rst        = ($urandom_range(499) == 0);
            cyc();
        end
        rst = 0; idle_inputs(); cyc();

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule